// File: doc/BRIEF.md
# PLL Reconfiguration Update Latch

This block holds the control registers that let software retune a fractional PLL while it keeps running. Software first fills three staging registers: the integer multiplier, the fractional word and a frequency-control word. It then sets a request bit in the mode register. The block carries that request into the reference-clock timing domain. On one reference tick it copies all three staged words at once into the active copies that drive the PLL core, and it returns an acknowledge flag. The reference domain is modelled by a one-cycle reference strobe.

The request is cleared in one of two ways. With the bypass bit clear, the block drops the request by itself once the acknowledge is visible. With the bypass bit set, the request stays set until software writes it back to zero. In both cases the acknowledge stays latched while the request is present, and it falls once the request has gone. The falling acknowledge tells software that the handshake is complete. A request is only taken while the core reports itself enabled. Otherwise only the staged words change.

Top module: `pll_upd_latch`

## Requirements
- R1: After reset, the staged words, the active words, the request bit, the bypass bit and the acknowledge bit are all zero.
- R2: Register address 1 holds the staged integer word, address 2 holds the staged fractional word and address 3 holds the staged frequency-control word. Each reads back what was written, with the bits above its width reading zero.
- R3: Writing 1 to mode bit 22 (request) at address 0 sets the request only while `core_active` is 1 and no earlier handshake is still in flight. Otherwise the request stays 0 and the active words are unchanged.
- R4: The three active words take the staged values together on the third reference tick after the request is set. `upd_strobe` is high for exactly the one cycle in which the new words first appear.
- R5: The active words change at no time other than that latch event. Staging writes made outside it leave them unchanged.
- R6: Mode bit 29 (acknowledge) reads 1 from the second clock cycle after `upd_strobe`.
- R7: With mode bit 23 (bypass) at 0, the request bit reads 0 from the cycle after the acknowledge first reads 1.
- R8: With the bypass bit at 1, the request and the acknowledge both stay 1 until software writes bit 22 to 0.
- R9: Once the request is 0, the acknowledge returns to 0.
- R10: Mode bit 31 reads `core_lock` and mode bit 30 reads `core_active`. Writes to bits 29 to 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe, once per reference-clock period |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register address (0 mode, 1 integer, 2 fraction, 3 frequency control) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_active | input | 1 | PLL core reports that it is enabled |
| core_lock | input | 1 | PLL core lock status |
| act_l | output | L_W | Active integer word |
| act_alpha | output | A_W | Active fractional word |
| act_frac_ctl | output | FC_W | Active frequency-control word |
| upd_strobe | output | 1 | One-cycle pulse when the active words change |

## Verification
The latch lands on the third reference tick after the request edge. The bench counts reference ticks itself and checks that this count is exactly three when it first sees `upd_strobe`. It then steps one clock at a time from that cycle. The acknowledge must still be low one cycle later and high two cycles later. In the automatic mode the request must read zero on the third cycle. In bypass mode both bits must hold for twenty cycles until software clears the request. The fall of the acknowledge depends on reference ticks, so the bench polls for it within a bound. All outputs are sampled on the falling clock edge, with bus reads taken one nanosecond after the address is set.

// File: rtl/pll_upd_pkg.sv
package pll_upd_pkg;
  localparam int DW      = 32;
  localparam int BIT_REQ = 22;
  localparam int BIT_BYP = 23;
  localparam int BIT_ACK = 29;
  localparam int BIT_ACT = 30;
  localparam int BIT_LCK = 31;

  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_LINT = 2'd1,
    A_FRAC = 2'd2,
    A_FCTL = 2'd3
  } reg_addr_e;

  // Builds the mode register read value from its individual flags.
  function automatic logic [DW-1:0] pack_mode(input logic lck, input logic act,
                                              input logic ack, input logic byp,
                                              input logic req);
    logic [DW-1:0] w;
    w          = '0;
    w[BIT_LCK] = lck;
    w[BIT_ACT] = act;
    w[BIT_ACK] = ack;
    w[BIT_BYP] = byp;
    w[BIT_REQ] = req;
    return w;
  endfunction
endpackage

// File: rtl/pll_upd_sync.sv
// Multi-flop synchronizer on the bus clock; busy is high while any stage is set.
module pll_upd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic busy
);
  logic [STAGES-1:0] chain;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[gi] <= 1'b0;
      else if (gi == 0) chain[gi] <= d;
      else chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign busy = |chain;
endmodule

// File: rtl/pll_upd_regs.sv
// Staging registers, mode bits, request acceptance and read multiplexer.
module pll_upd_regs
  import pll_upd_pkg::*;
#(
  parameter int L_W  = 16,
  parameter int A_W  = 32,
  parameter int FC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            core_active,
  input  logic            core_lock,
  input  logic            ack_stat,
  input  logic            hs_idle,
  output logic [L_W-1:0]  stg_l,
  output logic [A_W-1:0]  stg_alpha,
  output logic [FC_W-1:0] stg_fctl,
  output logic            upd_req,
  output logic            upd_byp,
  output logic [DW-1:0]   bus_rdata,
  output logic            sw_clr,
  output logic            req_take,
  output logic            auto_clr
);
  logic wr_mode;

  assign wr_mode  = bus_wr && (bus_addr == A_MODE);
  assign sw_clr   = wr_mode && !bus_wdata[BIT_REQ];
  assign req_take = wr_mode && bus_wdata[BIT_REQ] && !upd_req && core_active && hs_idle;
  assign auto_clr = ack_stat && upd_req && !upd_byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_req <= 1'b0;
      upd_byp <= 1'b0;
    end else begin
      if (auto_clr || sw_clr) upd_req <= 1'b0;
      else if (req_take)      upd_req <= 1'b1;
      if (wr_mode) upd_byp <= bus_wdata[BIT_BYP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_l     <= '0;
      stg_alpha <= '0;
      stg_fctl  <= '0;
    end else if (bus_wr) begin
      case (reg_addr_e'(bus_addr))
        A_LINT:  stg_l     <= bus_wdata[L_W-1:0];
        A_FRAC:  stg_alpha <= bus_wdata[A_W-1:0];
        A_FCTL:  stg_fctl  <= bus_wdata[FC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      A_MODE:  bus_rdata = pack_mode(core_lock, core_active, ack_stat, upd_byp, upd_req);
      A_LINT:  bus_rdata = DW'(stg_l);
      A_FRAC:  bus_rdata = DW'(stg_alpha);
      default: bus_rdata = DW'(stg_fctl);
    endcase
  end
endmodule

// File: rtl/pll_upd_refside.sv
// Reference-domain side: request synchronizer, single latch event, core acknowledge.
module pll_upd_refside #(
  parameter int L_W         = 16,
  parameter int A_W         = 32,
  parameter int FC_W        = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic            upd_req,
  input  logic [L_W-1:0]  stg_l,
  input  logic [A_W-1:0]  stg_alpha,
  input  logic [FC_W-1:0] stg_fctl,
  output logic [L_W-1:0]  act_l,
  output logic [A_W-1:0]  act_alpha,
  output logic [FC_W-1:0] act_fctl,
  output logic            ack_ref,
  output logic            latch_evt,
  output logic            upd_strobe,
  output logic            ref_busy
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   req_ref;

  for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_rsync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[gi] <= 1'b0;
      else if (ref_tick) begin
        if (gi == 0) chain[gi] <= upd_req;
        else         chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
      end
    end
  end

  assign req_ref   = chain[SYNC_STAGES-1];
  assign latch_evt = ref_tick && req_ref && !ack_ref;
  assign ref_busy  = (|chain) || ack_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_ref    <= 1'b0;
      upd_strobe <= 1'b0;
      act_l      <= '0;
      act_alpha  <= '0;
      act_fctl   <= '0;
    end else begin
      upd_strobe <= latch_evt;
      if (latch_evt) begin
        ack_ref   <= 1'b1;
        act_l     <= stg_l;
        act_alpha <= stg_alpha;
        act_fctl  <= stg_fctl;
      end else if (ref_tick && !req_ref) begin
        ack_ref <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pll_upd_latch.sv
module pll_upd_latch
  import pll_upd_pkg::*;
#(
  parameter int L_W       = 16,
  parameter int A_W       = 32,
  parameter int FC_W      = 12,
  parameter int REF_SYNC  = 2,
  parameter int ACK_SYNC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            core_active,
  input  logic            core_lock,
  output logic [L_W-1:0]  act_l,
  output logic [A_W-1:0]  act_alpha,
  output logic [FC_W-1:0] act_frac_ctl,
  output logic            upd_strobe
);
  logic [L_W-1:0]  stg_l;
  logic [A_W-1:0]  stg_alpha;
  logic [FC_W-1:0] stg_fctl;
  logic upd_req, upd_byp, sw_clr, req_take, auto_clr;
  logic ack_ref, ack_stat, ack_busy, latch_evt, ref_busy, hs_idle;

  assign hs_idle = !ref_busy && !ack_busy;

  pll_upd_regs #(.L_W(L_W), .A_W(A_W), .FC_W(FC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .core_active(core_active), .core_lock(core_lock),
    .ack_stat(ack_stat), .hs_idle(hs_idle), .stg_l(stg_l), .stg_alpha(stg_alpha),
    .stg_fctl(stg_fctl), .upd_req(upd_req), .upd_byp(upd_byp),
    .bus_rdata(bus_rdata), .sw_clr(sw_clr), .req_take(req_take), .auto_clr(auto_clr)
  );

  pll_upd_refside #(.L_W(L_W), .A_W(A_W), .FC_W(FC_W), .SYNC_STAGES(REF_SYNC)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .upd_req(upd_req),
    .stg_l(stg_l), .stg_alpha(stg_alpha), .stg_fctl(stg_fctl),
    .act_l(act_l), .act_alpha(act_alpha), .act_fctl(act_frac_ctl),
    .ack_ref(ack_ref), .latch_evt(latch_evt), .upd_strobe(upd_strobe),
    .ref_busy(ref_busy)
  );

  pll_upd_sync #(.STAGES(ACK_SYNC)) u_acksync (
    .clk(clk), .rst_n(rst_n), .d(ack_ref), .q(ack_stat), .busy(ack_busy)
  );
endmodule

// File: rtl/pll_upd_chk.sv
module pll_upd_chk #(
  parameter int L_W  = 16,
  parameter int A_W  = 32,
  parameter int FC_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic            core_active,
  input logic            core_lock,
  input logic            upd_req,
  input logic            upd_byp,
  input logic            sw_clr,
  input logic            ack_ref,
  input logic            ack_stat,
  input logic            latch_evt,
  input logic            upd_strobe,
  input logic [L_W-1:0]  act_l,
  input logic [A_W-1:0]  act_alpha,
  input logic [FC_W-1:0] act_frac_ctl
);
  a_r3_gate_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[22] && !upd_req && !core_active) |=> !upd_req);

  a_r4_strobe_follows_latch: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> upd_strobe);

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> ($stable(act_l) && $stable(act_alpha) && $stable(act_frac_ctl)));

  a_r6_ack_from_core: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_stat) |-> $past(ack_ref, 2));

  a_r7_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stat && upd_req && !upd_byp) |=> !upd_req);

  a_r8_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && upd_byp && !sw_clr) |=> upd_req);

  a_r10_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[31] == core_lock && bus_rdata[30] == core_active
                            && bus_rdata[29] == ack_stat));
endmodule

bind pll_upd_latch pll_upd_chk #(.L_W(L_W), .A_W(A_W), .FC_W(FC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_active(core_active),
  .core_lock(core_lock), .upd_req(upd_req), .upd_byp(upd_byp), .sw_clr(sw_clr),
  .ack_ref(ack_ref), .ack_stat(ack_stat), .latch_evt(latch_evt),
  .upd_strobe(upd_strobe), .act_l(act_l), .act_alpha(act_alpha),
  .act_frac_ctl(act_frac_ctl)
);

// File: tb/pll_upd_latch_test.sv
`timescale 1ns/1ps
module pll_upd_latch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_active = 1'b0;
  logic        core_lock = 1'b0;
  logic [15:0] act_l;
  logic [31:0] act_alpha;
  logic [11:0] act_frac_ctl;
  logic        upd_strobe;

  int n_chk = 0;
  int n_err = 0;
  int tick_cnt = 0;
  bit done = 1'b0;

  // bypass, integer, fraction, frequency control
  localparam logic [60:0] VECS [5] = '{
    {1'b0, 16'h0040, 32'h8000_0000, 12'h123},
    {1'b1, 16'h0033, 32'h1234_5678, 12'hABC},
    {1'b0, 16'hFFFF, 32'hFFFF_FFFF, 12'hFFF},
    {1'b1, 16'h0001, 32'h0000_0001, 12'h001},
    {1'b0, 16'h5A5A, 32'hDEAD_BEEF, 12'h7E5}
  };

  pll_upd_latch uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_active(core_active), .core_lock(core_lock), .act_l(act_l),
    .act_alpha(act_alpha), .act_frac_ctl(act_frac_ctl), .upd_strobe(upd_strobe)
  );

  always #2.5 clk = ~clk;

  initial begin : ref_gen
    forever begin
      repeat (3) begin @(negedge clk); ref_tick = 1'b0; end
      @(negedge clk); ref_tick = 1'b1;
    end
  end

  always @(posedge clk) if (ref_tick) tick_cnt <= tick_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_active(input string tag, input logic [15:0] l,
                            input logic [31:0] f, input logic [11:0] c);
    chk({tag, " integer"},  {16'h0, act_l}, {16'h0, l});
    chk({tag, " fraction"}, act_alpha, f);
    chk({tag, " freqctl"},  {20'h0, act_frac_ctl}, {20'h0, c});
  endtask

  task automatic run_update(input logic byp, input logic [15:0] l,
                            input logic [31:0] f, input logic [11:0] c);
    logic [31:0] m;
    int t0;
    bit seen;
    wr(2'd0, (32'(byp) << 23) | (32'h1 << 22));
    t0 = tick_cnt;
    rd(2'd0, m);
    chk("R3 request accepted", {31'h0, m[22]}, 32'h1);
    seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      seen = upd_strobe;
    end
    chk("R4 strobe seen", {31'h0, seen}, 32'h1);
    chk("R4 ticks to latch", tick_cnt - t0, 32'd3);
    chk_active("R4 latched", l, f, c);
    @(negedge clk);
    chk("R4 strobe one cycle", {31'h0, upd_strobe}, 32'h0);
    rd(2'd0, m);
    chk("R6 ack not yet", {31'h0, m[29]}, 32'h0);
    @(negedge clk);
    rd(2'd0, m);
    chk("R6 ack set", {31'h0, m[29]}, 32'h1);
    chk("R6 request still set", {31'h0, m[22]}, 32'h1);
    if (!byp) begin
      @(negedge clk);
      rd(2'd0, m);
      chk("R7 auto clear", {31'h0, m[22]}, 32'h0);
    end else begin
      repeat (20) @(negedge clk);
      rd(2'd0, m);
      chk("R8 request held", {31'h0, m[22]}, 32'h1);
      chk("R8 ack held", {31'h0, m[29]}, 32'h1);
      wr(2'd0, 32'h1 << 23);
    end
    seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      rd(2'd0, m);
      seen = !m[29];
    end
    chk("R9 ack cleared", {31'h0, seen}, 32'h1);
    chk("R9 request zero", {31'h0, m[22]}, 32'h0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), m);
      chk("R1 register reset", m, 32'h0);
    end
    chk_active("R1 active reset", 16'h0, 32'h0, 12'h0);

    // R2 widths and readback
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd2, 32'hCAFE_F00D);
    rd(2'd1, m); chk("R2 integer width", m, 32'h0000_FFFF);
    rd(2'd3, m); chk("R2 freqctl width", m, 32'h0000_0FFF);
    rd(2'd2, m); chk("R2 fraction", m, 32'hCAFE_F00D);
    chk_active("R5 staging no effect", 16'h0, 32'h0, 12'h0);

    core_active = 1'b1;
    core_lock   = 1'b1;
    foreach (VECS[i]) begin
      wr(2'd1, 32'(VECS[i][59:44]));
      wr(2'd2, VECS[i][43:12]);
      wr(2'd3, 32'(VECS[i][11:0]));
      rd(2'd1, m); chk("R2 integer readback", m, 32'(VECS[i][59:44]));
      run_update(VECS[i][60], VECS[i][59:44], VECS[i][43:12], VECS[i][11:0]);
    end

    // R5: staging writes after latch leave active words alone
    wr(2'd1, 32'h0000_1111);
    wr(2'd2, 32'h2222_2222);
    wr(2'd3, 32'h0000_0333);
    repeat (30) @(negedge clk);
    chk_active("R5 active stable", 16'h5A5A, 32'hDEAD_BEEF, 12'h7E5);

    // R3: request while core disabled is refused
    core_active = 1'b0;
    wr(2'd0, 32'h1 << 22);
    rd(2'd0, m);
    chk("R3 refused when inactive", {31'h0, m[22]}, 32'h0);
    repeat (40) @(negedge clk);
    chk_active("R3 active unchanged", 16'h5A5A, 32'hDEAD_BEEF, 12'h7E5);
    rd(2'd1, m);
    chk("R3 staging still written", m, 32'h0000_1111);

    // R10: status bits follow core, writes ignored
    core_active = 1'b1;
    core_lock   = 1'b0;
    wr(2'd0, 32'hE000_0000);
    rd(2'd0, m);
    chk("R10 mode after RO write", m, 32'h4000_0000);
    core_lock = 1'b1;
    core_active = 1'b0;
    #1;
    rd(2'd0, m);
    chk("R10 lock and active follow", m, 32'h8000_0000);

    // a last update after everything else
    core_active = 1'b1;
    run_update(1'b0, 16'h1111, 32'h2222_2222, 12'h333);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule